// File: doc/BRIEF.md
# Error Status Capture Bank

This block records hardware error reports for software to inspect. Each report arrives as a one-cycle strobe with a source index, an uncorrected indication, address-valid and misc-valid indications, an address, a miscellaneous data word and a 16-bit error code. The block packs the report's flags and code into a 64-bit status word. It loads a companion address register and a companion misc register from the report. A per-source enable mask in a control register supplies the enabled flag of each captured entry.

A report that arrives while the stored entry is still valid sets a sticky overflow flag. A severity policy then decides whether the newcomer takes the slot. When it does not, its address, misc data and code are dropped.

Software uses a simple register port. It reads any of the four registers and rewrites the control and status registers. It may only zero the address and misc registers. A write that carries any 1 to those two registers is refused and raises a one-cycle fault strobe.

Top module: `errStatusBank`

## Requirements
- R1: A synchronous active-high reset clears the control, status, address and misc registers to zero and holds the fault strobe low.
- R2: A report into a bank whose valid bit (bit 63) is clear is visible on the next cycle. Bit 63 is set. Bit 61 is uncorrected, bit 60 is enabled, bit 59 is misc-valid, bit 58 is address-valid and bits 15:0 are the error code. Bit 62 is unchanged and every other bit is zero.
- R3: The enabled flag of a captured entry equals the control-register bit selected by the report's source index.
- R4: A report that arrives while bit 63 is set sets overflow (bit 62). The flag stays set until software writes the status register.
- R5: When an entry is valid, a newcomer takes the slot if the stored entry is corrected and either the newcomer is uncorrected or the newcomer is enabled and the stored entry is disabled.
- R6: A newcomer never replaces a stored valid uncorrected entry. The stored code, flags, address and misc data are kept.
- R7: A newcomer that does not take the slot leaves the address, misc and code unchanged and only sets overflow.
- R8: On a capture, the address register loads the report address when address-valid is set and zero otherwise. The misc register likewise loads the report's misc data when misc-valid is set and zero otherwise.
- R9: A software write to the status register stores the written 64-bit value.
- R10: A write of all zeros to the address or misc register clears it. A write with any bit at 1, reserved bits included, leaves the register unchanged and pulses the fault strobe high on the cycle after the write.
- R11: When a report and a software status write fall in the same cycle, the report is applied and the write is dropped.
- R12: Register select codes are 0 for control, 1 for status, 2 for address and 3 for misc. The control register holds NUM_SRC writable bits, and the bits above them read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evValid | input | 1 | Error report strobe |
| evSrc | input | SRC_W | Reporting source index |
| evUncorr | input | 1 | Report is uncorrected |
| evAddrValid | input | 1 | Report address is meaningful |
| evMiscValid | input | 1 | Report misc data is meaningful |
| evAddr | input | ADDR_W | Report address |
| evMisc | input | MISC_W | Report misc data |
| evCode | input | 16 | Report error code |
| regSel | input | 2 | Register select for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data of the selected register |
| faultPulse | output | 1 | One-cycle strobe after a refused write |

## Verification
The capture path is driven with report sequences that pair every stored class (corrected or uncorrected, enabled or disabled) with a colliding newcomer of another class. Comparing the surviving code separates a design that replaces from one that keeps, and the overflow bit shows that each collision was seen. Reports with and without address-valid and misc-valid separate loading from zeroing of the companion registers. Writes of zeros, of a 1 in a low bit and of a 1 in a reserved bit tell a clear apart from a refused write.

// File: rtl/errBankPkg.sv
package errBankPkg;

  localparam int STATUS_W  = 64;
  localparam int CODE_W    = 16;
  localparam int BIT_VAL   = 63;
  localparam int BIT_OVER  = 62;
  localparam int BIT_UC    = 61;
  localparam int BIT_EN    = 60;
  localparam int BIT_MISCV = 59;
  localparam int BIT_ADDRV = 58;

  typedef enum logic [1:0] {
    SEL_CTL    = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_MISC   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // report takes the slot
    logic setOver;     // report collided with a valid entry
    logic newEn;       // enabled flag for a loaded entry
    logic swStatusWr;  // software status write accepted
    logic swCtlWr;     // software control write
    logic swAddrClr;   // software address clear accepted
    logic swMiscClr;   // software misc clear accepted
  } ctrlStrb_t;

endpackage

// File: rtl/errClrReg.sv
module errClrReg #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         loadValid,
  input  logic [W-1:0] loadData,
  input  logic         clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= loadValid ? loadData : '0;
    else if (clr)   q <= '0;
  end

  // R10
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (q == $past(q)) || (q == '0));

endmodule

// File: rtl/errBankCtrl.sv
module errBankCtrl
  import errBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evValid,
  input  logic [SRC_W-1:0]   evSrc,
  input  logic               evUncorr,
  input  logic [NUM_SRC-1:0] ctlBits,
  input  logic               storedVal,
  input  logic               storedUc,
  input  logic               storedEn,
  input  logic               regWrEn,
  input  regSel_e            regSel,
  input  logic [63:0]        regWrData,
  output ctrlStrb_t          strb,
  output logic               faultPulse
);

  logic newEn, winNew, zeroData, wrAddr, wrMisc, illegal;

  always_comb begin
    newEn = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (int'(evSrc) == i) newEn = ctlBits[i];
  end

  // severity policy: stored uncorrected is final; otherwise the newcomer
  // wins by being uncorrected, or enabled against a disabled entry
  assign winNew   = !storedUc && (evUncorr || (newEn && !storedEn));
  assign zeroData = (regWrData == '0);
  assign wrAddr   = regWrEn && (regSel == SEL_ADDR);
  assign wrMisc   = regWrEn && (regSel == SEL_MISC);
  assign illegal  = (wrAddr || wrMisc) && !zeroData;

  always_comb begin
    strb            = '0;
    strb.load       = evValid && (!storedVal || winNew);
    strb.setOver    = evValid && storedVal;
    strb.newEn      = newEn;
    strb.swStatusWr = regWrEn && (regSel == SEL_STATUS) && !evValid;
    strb.swCtlWr    = regWrEn && (regSel == SEL_CTL);
    strb.swAddrClr  = wrAddr && zeroData && !strb.load;
    strb.swMiscClr  = wrMisc && zeroData && !strb.load;
  end

  always_ff @(posedge clk) begin
    if (rst) faultPulse <= 1'b0;
    else     faultPulse <= illegal;
  end

endmodule

// File: rtl/errBankData.sv
module errBankData
  import errBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 48,
  parameter int MISC_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrb_t          strb,
  input  logic               evUncorr,
  input  logic               evAddrValid,
  input  logic               evMiscValid,
  input  logic [ADDR_W-1:0]  evAddr,
  input  logic [MISC_W-1:0]  evMisc,
  input  logic [CODE_W-1:0]  evCode,
  input  regSel_e            regSel,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  output logic [63:0]        statusWord,
  output logic [NUM_SRC-1:0] ctlBits
);

  localparam int GAP_W = BIT_ADDRV - CODE_W;

  logic [63:0]       statusReg;
  logic [63:0]       newWord;
  logic [ADDR_W-1:0] addrReg;
  logic [MISC_W-1:0] miscReg;

  assign newWord = {1'b1, statusReg[BIT_OVER] | strb.setOver, evUncorr,
                    strb.newEn, evMiscValid, evAddrValid,
                    {GAP_W{1'b0}}, evCode};

  always_ff @(posedge clk) begin
    if (rst)                  statusReg <= '0;
    else if (strb.load)       statusReg <= newWord;
    else if (strb.setOver)    statusReg[BIT_OVER] <= 1'b1;
    else if (strb.swStatusWr) statusReg <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (rst)               ctlBits <= '0;
    else if (strb.swCtlWr) ctlBits <= regWrData[NUM_SRC-1:0];
  end

  errClrReg #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(strb.load), .loadValid(evAddrValid),
    .loadData(evAddr), .clr(strb.swAddrClr), .q(addrReg));

  errClrReg #(.W(MISC_W)) u_misc (
    .clk(clk), .rst(rst), .load(strb.load), .loadValid(evMiscValid),
    .loadData(evMisc), .clr(strb.swMiscClr), .q(miscReg));

  assign statusWord = statusReg;

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_CTL:    regRdData[NUM_SRC-1:0] = ctlBits;
      SEL_STATUS: regRdData              = statusReg;
      SEL_ADDR:   regRdData[ADDR_W-1:0]  = addrReg;
      SEL_MISC:   regRdData[MISC_W-1:0]  = miscReg;
      default:    regRdData              = '0;
    endcase
  end

  // R9
  sw_status_chk: assert property (@(posedge clk) disable iff (rst)
    strb.swStatusWr |=> statusReg == $past(regWrData));

  // R4
  over_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    statusReg[BIT_OVER] && !strb.swStatusWr |=> statusReg[BIT_OVER]);

endmodule

// File: rtl/errStatusBank.sv
module errStatusBank
  import errBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 48,
  parameter int MISC_W  = 32,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evValid,
  input  logic [SRC_W-1:0]  evSrc,
  input  logic              evUncorr,
  input  logic              evAddrValid,
  input  logic              evMiscValid,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [MISC_W-1:0] evMisc,
  input  logic [15:0]       evCode,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              faultPulse
);

  ctrlStrb_t          strb;
  logic [63:0]        statusWord;
  logic [NUM_SRC-1:0] ctlBits;
  regSel_e            selE;

  assign selE = regSel_e'(regSel);

  errBankCtrl #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ctrl (
    .clk(clk), .rst(rst), .evValid(evValid), .evSrc(evSrc),
    .evUncorr(evUncorr), .ctlBits(ctlBits),
    .storedVal(statusWord[BIT_VAL]), .storedUc(statusWord[BIT_UC]),
    .storedEn(statusWord[BIT_EN]), .regWrEn(regWrEn), .regSel(selE),
    .regWrData(regWrData), .strb(strb), .faultPulse(faultPulse));

  errBankData #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MISC_W(MISC_W)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .evUncorr(evUncorr),
    .evAddrValid(evAddrValid), .evMiscValid(evMiscValid),
    .evAddr(evAddr), .evMisc(evMisc), .evCode(evCode), .regSel(selE),
    .regWrData(regWrData), .regRdData(regRdData),
    .statusWord(statusWord), .ctlBits(ctlBits));

  // R2
  val_set_chk: assert property (@(posedge clk) disable iff (rst)
    evValid |=> statusWord[BIT_VAL]);

  // R6
  uc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    evValid && evUncorr && statusWord[BIT_VAL] && statusWord[BIT_UC]
    |=> statusWord[BIT_UC] && (statusWord[15:0] == $past(statusWord[15:0])));

endmodule

// File: tb/errStatusBank_tb.sv
`timescale 1ns/1ps
module errStatusBank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evValid = 1'b0;
  logic [2:0]  evSrc = '0;
  logic        evUncorr = 1'b0, evAddrValid = 1'b0, evMiscValid = 1'b0;
  logic [47:0] evAddr = '0;
  logic [31:0] evMisc = '0;
  logic [15:0] evCode = '0;
  logic [1:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        faultPulse;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  errStatusBank u_dut (
    .clk(clk), .rst(rst), .evValid(evValid), .evSrc(evSrc),
    .evUncorr(evUncorr), .evAddrValid(evAddrValid), .evMiscValid(evMiscValid),
    .evAddr(evAddr), .evMisc(evMisc), .evCode(evCode), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .faultPulse(faultPulse));

  typedef struct packed {
    logic        clr;
    logic [2:0]  src;
    logic        uc;
    logic        av;
    logic        mv;
    logic [15:0] code;
    logic [63:0] exp;
  } vec_t;

  // control mask 0x0F: sources 0..3 enabled, 4..7 disabled
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0011, 64'h9400_0000_0000_0011}, // R2 R3
    '{1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0022, 64'hD400_0000_0000_0011}, // R4 keep
    '{1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 16'h0033, 64'h8800_0000_0000_0033}, // R3 disabled
    '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0044, 64'hD400_0000_0000_0044}, // R5 en over dis
    '{1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 16'h0055, 64'hE000_0000_0000_0055}, // R5 uc over corr
    '{1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 16'h0066, 64'hE000_0000_0000_0055}, // R6
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0077, 64'hB000_0000_0000_0077}, // R2
    '{1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 16'h0088, 64'hF000_0000_0000_0077}  // R6 R4
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    @(negedge clk);
    regSel = s;
    #1 v = regRdData;
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d, output logic flt);
    @(negedge clk);
    regSel = s; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    flt = faultPulse;
  endtask

  task automatic rep(input logic [2:0] s, input logic uc, input logic av,
                     input logic mv, input logic [15:0] code,
                     input logic [47:0] a, input logic [31:0] m);
    @(negedge clk);
    evValid = 1'b1; evSrc = s; evUncorr = uc; evAddrValid = av;
    evMiscValid = mv; evCode = code; evAddr = a; evMisc = m;
    @(negedge clk);
    evValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic f;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      chk("R1 register zero", v, 64'h0);
    end
    chk("R1 fault low", {63'h0, faultPulse}, 64'h0);

    // R12 control width and select code 0
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, f);
    rd(2'd0, v);
    chk("R12 control readback", v, 64'h0000_0000_0000_00FF);
    wr(2'd0, 64'h0F, f);

    // vector table
    for (int i = 0; i < 8; i++) begin
      if (VECS[i].clr) wr(2'd1, 64'h0, f);
      rep(VECS[i].src, VECS[i].uc, VECS[i].av, VECS[i].mv, VECS[i].code,
          48'h0, 32'h0);
      rd(2'd1, v);
      chk($sformatf("R2-R6 vector %0d", i), v, VECS[i].exp);
    end

    // R8 companion registers loaded
    wr(2'd1, 64'h0, f);
    rep(3'd1, 1'b0, 1'b1, 1'b1, 16'h0A0A, 48'h1234_5678_9ABC, 32'hDEAD_BEEF);
    rd(2'd2, v);
    chk("R8 address loaded", v, 64'h0000_1234_5678_9ABC);
    rd(2'd3, v);
    chk("R8 misc loaded", v, 64'h0000_0000_DEAD_BEEF);
    // R8 companion registers zeroed when flags clear
    wr(2'd1, 64'h0, f);
    rep(3'd1, 1'b0, 1'b0, 1'b0, 16'h0B0B, 48'hFFFF_0000_1111, 32'h5555_AAAA);
    rd(2'd2, v);
    chk("R8 address zeroed", v, 64'h0);
    rd(2'd3, v);
    chk("R8 misc zeroed", v, 64'h0);

    // R7 loser discarded
    wr(2'd1, 64'h0, f);
    rep(3'd0, 1'b1, 1'b1, 1'b1, 16'h0101, 48'hAAAA_0000_0001, 32'h1111_1111);
    rep(3'd1, 1'b1, 1'b1, 1'b1, 16'h0202, 48'hBBBB_0000_0002, 32'h2222_2222);
    rd(2'd1, v);
    chk("R7 status kept", v, 64'hFC00_0000_0000_0101);
    rd(2'd2, v);
    chk("R7 address kept", v, 64'h0000_AAAA_0000_0001);
    rd(2'd3, v);
    chk("R7 misc kept", v, 64'h0000_0000_1111_1111);

    // R10 refused writes
    wr(2'd2, 64'h1, f);
    chk("R10 fault on low bit", {63'h0, f}, 64'h1);
    rd(2'd2, v);
    chk("R10 address unchanged", v, 64'h0000_AAAA_0000_0001);
    wr(2'd2, 64'h0004_0000_0000_0000, f);
    chk("R10 fault on reserved bit", {63'h0, f}, 64'h1);
    wr(2'd2, 64'h0, f);
    chk("R10 no fault on zero", {63'h0, f}, 64'h0);
    rd(2'd2, v);
    chk("R10 address cleared", v, 64'h0);
    wr(2'd3, 64'h8000_0000, f);
    chk("R10 misc fault", {63'h0, f}, 64'h1);
    wr(2'd3, 64'h0, f);
    rd(2'd3, v);
    chk("R10 misc cleared", v, 64'h0);

    // R4 overflow persists across idle and other writes
    repeat (4) @(negedge clk);
    rd(2'd1, v);
    chk("R4 overflow sticky", v, 64'hFC00_0000_0000_0101);

    // R11 simultaneous report and status write
    wr(2'd1, 64'h0, f);
    @(negedge clk);
    evValid = 1'b1; evSrc = 3'd2; evUncorr = 1'b0; evAddrValid = 1'b0;
    evMiscValid = 1'b0; evCode = 16'h0303;
    regSel = 2'd1; regWrEn = 1'b1; regWrData = 64'h0;
    @(negedge clk);
    evValid = 1'b0; regWrEn = 1'b0;
    rd(2'd1, v);
    chk("R11 report wins", v, 64'h9000_0000_0000_0303);

    // R9 arbitrary status write
    wr(2'd1, 64'h0123_4567_89AB_CDEF, f);
    rd(2'd1, v);
    chk("R9 status write", v, 64'h0123_4567_89AB_CDEF);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2'd1, v);
    chk("R1 status after reset", v, 64'h0);
    rd(2'd0, v);
    chk("R1 control after reset", v, 64'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule